// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Fast Redirect

This block sits between a bank of interrupt pending flags and a CPU core. It picks one pending source and presents it as a single request word. The word carries the source's 4-bit priority and its 8-bit number. The block holds that request until the core acknowledges it. Only one request is outstanding at any time.

Each source's priority is not stored per source. A per-source map selects one of a smaller set of priority slots, so several sources can share one priority value. The flag latch that records events, the sense configuration and the slot values are all supplied from outside as plain vectors.

While idle, the block issues a request as soon as a pending flag newly rises, without comparing priorities. On an acknowledge it rescans every waiting source in one cycle and picks the highest priority among them. One configurable source number can be diverted to a separate fast-interrupt output instead of the normal one. A level-sensed source that drops while outstanding has its request withdrawn.

Top module: `irq_arbiter`

## Requirements
- R1: While idle, a source whose pending flag rises (low in the previous cycle, high now) is requested in the cycle after the rise, but only if its enable bit is 1 and its number is not 0. When several such sources rise in the same cycle, the lowest-numbered one is taken.
- R2: The request word holds zeros in bits 15:12, the source priority in bits 11:8 and the source number in bits 7:0.
- R3: A source's priority is the value of the slot named by its map field. Source s uses map bits [s*SLOT_W +: SLOT_W], and slot k uses priority bits [4k +: 4]. A map field that points past the last slot gives priority 0.
- R4: A request raises `firq_o` if `fast_en_i` is 1 and `fast_vec_i` equals the source number at the moment of issue. Otherwise it raises `irq_o`.
- R5: An acknowledge while a request is outstanding clears it. In the same edge, all pending sources are scanned and the strictly highest priority wins, with the lowest number winning ties. The just-acknowledged source takes part in the scan only if it is level-sensed (sense bit 1). The winner is requested in the next cycle only if it is enabled and nonzero; otherwise the block goes idle.
- R6: During the rescan, a source whose priority is 0 is never chosen.
- R7: If the outstanding source is level-sensed and its pending flag is low (without an acknowledge), the next cycle shows both outputs low and a word of 0, and the block is idle.
- R8: An acknowledge while idle changes nothing.
- R9: While idle, a newly risen source is requested even when an older pending source has a higher priority.
- R10: While a request is outstanding and neither an acknowledge nor a withdrawal occurs, the word and both request outputs stay unchanged, and new rises are ignored.
- R11: After reset both request outputs are low and the word is 0.
- R12: `irq_o` and `firq_o` are never high together, and the word is 0 whenever both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_SRC | Pending flag per source |
| en_i | input | NUM_SRC | Enable bit per source |
| lvl_i | input | NUM_SRC | Sense per source: 1 level, 0 edge |
| slot_sel_i | input | NUM_SRC*SLOT_W | Per-source priority slot index |
| slot_prio_i | input | NUM_SLOT*4 | 4-bit priority per slot |
| fast_en_i | input | 1 | Fast redirect enable |
| fast_vec_i | input | 8 | Source number diverted to the fast output |
| ack_i | input | 1 | Acknowledge pulse from the core |
| irq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |
| req_word_o | output | 16 | Priority and source number of the request |

## Verification
A corrupted outstanding-source register shows up one cycle later, in one of two ways. If the acknowledged source is wrongly kept out of the rescan, or wrongly let back in, the next request word names the wrong source. If the level-drop check reads the wrong flag, a request is withdrawn at the wrong time. A broken tie or comparison in the rescan tree shows up as the wrong source number in the word on the first cycle after an acknowledge. Mistakes in the slot lookup or in the fast-route compare show up in bits 11:8 of the word, or on the wrong request pin, in the same cycle the request appears.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 4;
  localparam int IDX_W  = 8;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } cand_t;

  // the higher-numbered side wins only with a strictly larger priority
  function automatic cand_t cand_pick(cand_t lo, cand_t hi);
    if (hi.vld && (!lo.vld || hi.prio > lo.prio)) return hi;
    return lo;
  endfunction

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} arb_state_t;
endpackage

// File: rtl/irq_arb_prio_map.sv
module irq_arb_prio_map
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic [NUM_SRC*SLOT_W-1:0]  slot_sel_i,
  input  logic [NUM_SLOT*PRIO_W-1:0] slot_prio_i,
  output logic [NUM_SRC*PRIO_W-1:0]  src_prio_o
);
  logic [PRIO_W-1:0] tab [NUM_SLOT];

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_tab
    assign tab[k] = slot_prio_i[k*PRIO_W +: PRIO_W];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [SLOT_W-1:0] sel;
    assign sel = slot_sel_i[s*SLOT_W +: SLOT_W];
    assign src_prio_o[s*PRIO_W +: PRIO_W] =
      (32'(sel) < NUM_SLOT) ? tab[sel] : '0;
  end
endmodule

// File: rtl/irq_arb_max_tree.sv
module irq_arb_max_tree
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LEAVES = 1 << LVLS,
  localparam int PPAD_W = LEAVES * PRIO_W
) (
  input  logic [NUM_SRC-1:0]        vld_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output cand_t                     best_o
);
  logic [LEAVES-1:0] vld_pad;
  logic [PPAD_W-1:0] prio_pad;
  cand_t             node [2*LEAVES-1];

  assign vld_pad  = LEAVES'(vld_i);
  assign prio_pad = PPAD_W'(prio_i);

  // heap layout: leaf j at LEAVES-1+j, children of i at 2i+1 (lower) and 2i+2
  always_comb begin
    for (int j = 0; j < LEAVES; j++) begin
      node[LEAVES-1+j].vld  = vld_pad[j];
      node[LEAVES-1+j].prio = prio_pad[j*PRIO_W +: PRIO_W];
      node[LEAVES-1+j].idx  = IDX_W'(j);
    end
    for (int i = LEAVES-2; i >= 0; i--) begin
      node[i] = cand_pick(node[2*i+1], node[2*i+2]);
    end
    best_o = node[0];
  end
endmodule

// File: rtl/irq_arb_first_set.sv
module irq_arb_first_set #(
  parameter int NUM_SRC = 32,
  localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               found_o,
  output logic [IW-1:0]      idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         pend_i,
  input  logic [NUM_SRC-1:0]         en_i,
  input  logic [NUM_SRC-1:0]         lvl_i,
  input  logic [NUM_SRC*SLOT_W-1:0]  slot_sel_i,
  input  logic [NUM_SLOT*PRIO_W-1:0] slot_prio_i,
  input  logic                       fast_en_i,
  input  logic [IDX_W-1:0]           fast_vec_i,
  input  logic                       ack_i,
  output logic                       irq_o,
  output logic                       firq_o,
  output logic [WORD_W-1:0]          req_word_o
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  arb_state_t          state_q;
  logic [IW-1:0]       cur_q;
  logic [NUM_SRC-1:0]  pend_q;

  logic [NUM_SRC*PRIO_W-1:0] src_prio;
  logic [PRIO_W-1:0]         prio_a [NUM_SRC];
  logic [NUM_SRC-1:0]        prio_nz;

  irq_arb_prio_map #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_map (
    .slot_sel_i (slot_sel_i),
    .slot_prio_i(slot_prio_i),
    .src_prio_o (src_prio)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_unpack
    assign prio_a[s]  = src_prio[s*PRIO_W +: PRIO_W];
    assign prio_nz[s] = |src_prio[s*PRIO_W +: PRIO_W];
  end

  // newly risen, enabled, nonzero sources
  logic [NUM_SRC-1:0] rise_ok;
  logic               new_found;
  logic [IW-1:0]      new_idx;

  assign rise_ok = pend_i & ~pend_q & en_i & ~NUM_SRC'(1);

  irq_arb_first_set #(.NUM_SRC(NUM_SRC)) u_first (
    .vec_i  (rise_ok),
    .found_o(new_found),
    .idx_o  (new_idx)
  );

  // rescan over waiting sources; an edge-sensed acknowledged source drops out
  logic               busy;
  logic               cur_lvl;
  logic               cur_pend;
  logic [NUM_SRC-1:0] excl;
  logic [NUM_SRC-1:0] scan_vld;
  cand_t              best;
  logic [IW-1:0]      best_idx;

  assign busy     = (state_q == ST_BUSY);
  assign cur_lvl  = lvl_i[cur_q];
  assign cur_pend = pend_i[cur_q];
  assign excl     = (busy && !cur_lvl) ? (NUM_SRC'(1) << cur_q) : '0;
  assign scan_vld = pend_i & ~excl & prio_nz;
  assign best_idx = best.idx[IW-1:0];

  irq_arb_max_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .vld_i (scan_vld),
    .prio_i(src_prio),
    .best_o(best)
  );

  // next-state selection
  logic          do_issue;
  logic          do_clear;
  logic [IW-1:0] issue_idx;

  always_comb begin
    do_issue  = 1'b0;
    do_clear  = 1'b0;
    issue_idx = new_idx;
    if (busy) begin
      if (ack_i) begin
        do_clear = 1'b1;
        if (best.vld && (best.idx != '0) && en_i[best_idx]) begin
          do_issue  = 1'b1;
          issue_idx = best_idx;
        end
      end else if (cur_lvl && !cur_pend) begin
        do_clear = 1'b1;
      end
    end else if (new_found) begin
      do_issue = 1'b1;
    end
  end

  logic              issue_fast;
  logic [WORD_W-1:0] issue_word;

  assign issue_fast = fast_en_i && (fast_vec_i == IDX_W'(issue_idx));
  assign issue_word = {{(WORD_W-PRIO_W-IDX_W){1'b0}}, prio_a[issue_idx],
                       IDX_W'(issue_idx)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      pend_q     <= '0;
      irq_o      <= 1'b0;
      firq_o     <= 1'b0;
      req_word_o <= '0;
    end else begin
      pend_q <= pend_i;
      if (do_issue) begin
        state_q    <= ST_BUSY;
        cur_q      <= issue_idx;
        irq_o      <= !issue_fast;
        firq_o     <= issue_fast;
        req_word_o <= issue_word;
      end else if (do_clear) begin
        state_q    <= ST_IDLE;
        irq_o      <= 1'b0;
        firq_o     <= 1'b0;
        req_word_o <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_SRC-1:0]         pend_i,
  input logic [NUM_SRC-1:0]         en_i,
  input logic [NUM_SRC-1:0]         lvl_i,
  input logic                       fast_en_i,
  input logic [IDX_W-1:0]           fast_vec_i,
  input logic                       ack_i,
  input logic                       irq_o,
  input logic                       firq_o,
  input logic [WORD_W-1:0]          req_word_o
);
  logic               outq;
  logic [IW-1:0]      w_idx;
  logic               w_lvl;
  logic               w_pend;
  logic [NUM_SRC-1:0] pend_prev;
  logic               fresh;

  assign outq   = irq_o | firq_o;
  assign w_idx  = req_word_o[IW-1:0];
  assign w_lvl  = lvl_i[w_idx];
  assign w_pend = pend_i[w_idx];
  assign fresh  = |(pend_i & ~pend_prev & en_i & ~NUM_SRC'(1));

  always_ff @(posedge clk) begin
    if (rst) pend_prev <= '0;
    else     pend_prev <= pend_i;
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && firq_o)); // R12

  AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !outq |-> (req_word_o == '0)); // R12

  AST_WORD_FORMAT: assert property (@(posedge clk) disable iff (rst)
    outq |-> (req_word_o[15:12] == 4'd0 && req_word_o[7:0] != 8'd0)); // R2

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (outq && !ack_i && !(w_lvl && !w_pend)) |=>
      ($stable(req_word_o) && $stable(irq_o) && $stable(firq_o))); // R10

  AST_LEVEL_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
    (outq && !ack_i && w_lvl && !w_pend) |=> !outq); // R7

  AST_ACK_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    (!outq && ack_i && !fresh) |=> !outq); // R8

  AST_FAST_ROUTE: assert property (@(posedge clk) disable iff (rst)
    $rose(outq) |->
      (firq_o == ($past(fast_en_i) && ($past(fast_vec_i) == req_word_o[7:0])))); // R4
endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pend_i    (pend_i),
  .en_i      (en_i),
  .lvl_i     (lvl_i),
  .fast_en_i (fast_en_i),
  .fast_vec_i(fast_vec_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .firq_o    (firq_o),
  .req_word_o(req_word_o)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int NS = 16;
  localparam int NK = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [NS-1:0] pend, en, lvl;
  logic [NS*SW-1:0] slot_sel;
  logic [NK*4-1:0]  slot_prio;
  logic          fast_en;
  logic [7:0]    fast_vec;
  logic          ack;
  logic          irq, firq;
  logic [15:0]   word;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_arbiter #(.NUM_SRC(NS), .NUM_SLOT(NK)) uut (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .lvl_i(lvl),
    .slot_sel_i(slot_sel), .slot_prio_i(slot_prio),
    .fast_en_i(fast_en), .fast_vec_i(fast_vec), .ack_i(ack),
    .irq_o(irq), .firq_o(firq), .req_word_o(word)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [3:0] prio_of(int s);
    int sl;
    sl = int'(slot_sel[SW*s +: SW]);
    return slot_prio[4*sl +: 4];
  endfunction

  // strictly greater than the best so far, starting from 0: lowest wins ties
  function automatic int scan_expect(logic [NS-1:0] p, int excl);
    int best, bp;
    best = -1;
    bp = 0;
    for (int i = 0; i < NS; i++) begin
      if (p[i] && i != excl && int'(prio_of(i)) > bp) begin
        best = i;
        bp = int'(prio_of(i));
      end
    end
    return best;
  endfunction

  task automatic expect_out(string tag, logic ei, logic ef, logic [15:0] ew);
    nchk++;
    if (irq !== ei || firq !== ef || word !== ew) begin
      nerr++;
      $display("FAIL %s: actual irq=%0b firq=%0b word=%h expected irq=%0b firq=%0b word=%h",
               tag, irq, firq, word, ei, ef, ew);
    end
  endtask

  task automatic exp_issue(string tag, int s);
    logic f;
    f = fast_en && (fast_vec == 8'(s));
    expect_out(tag, !f, f, {4'd0, prio_of(s), 8'(s)});
  endtask

  task automatic exp_idle(string tag);
    expect_out(tag, 1'b0, 1'b0, 16'h0000);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pend = '0;
    ack = 1'b0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic default_cfg();
    en = '1;
    lvl = '0;
    fast_en = 1'b0;
    fast_vec = 8'd0;
    for (int s = 0; s < NS; s++) slot_sel[SW*s +: SW] = 2'(s);
    slot_prio = {4'd12, 4'd9, 4'd4, 4'd6};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    default_cfg();
    do_reset();
    exp_idle("R11 reset state");

    // R1 R2 R3: each source alone
    for (int s = 0; s < NS; s++) begin
      pend = 16'(1) << s;
      tick();
      if (s == 0) exp_idle("R1 source 0 never requested");
      else exp_issue("R2 R3 single source word", s);
      pend = '0;
      ack_pulse();
      exp_idle("R5 ack with nothing waiting");
    end

    // R3: remap a source to another slot, change that slot's value
    slot_sel[SW*5 +: SW] = 2'd3;
    slot_prio[15:12] = 4'd15;
    pend = 16'(1) << 5;
    tick();
    expect_out("R3 remapped slot", 1'b1, 1'b0, 16'h0F05);
    pend = '0;
    ack_pulse();
    default_cfg();

    // R1: disabled sources are not requested
    en = '0;
    for (int s = 1; s < NS; s++) begin
      pend = 16'(1) << s;
      tick();
      exp_idle("R1 disabled source");
      pend = '0;
      tick();
    end
    en = '1;

    // R4: fast redirect sweep
    for (int v = 0; v < 2; v++) begin
      fast_en = 1'b1;
      fast_vec = (v == 0) ? 8'd3 : 8'd9;
      for (int s = 1; s < NS; s++) begin
        pend = 16'(1) << s;
        tick();
        exp_issue("R4 fast routing", s);
        pend = '0;
        ack_pulse();
      end
    end
    fast_en = 1'b0;
    fast_vec = 8'd3;
    pend = 16'(1) << 3;
    tick();
    expect_out("R4 fast disabled", 1'b1, 1'b0, {4'd0, prio_of(3), 8'd3});
    pend = '0;
    ack_pulse();
    fast_vec = 8'd0;

    // R1: simultaneous rises, then R5 rescan landing on source 0
    do_reset();
    pend = 16'h0241;
    tick();
    exp_issue("R1 lowest simultaneous rise", 6);
    ack_pulse();
    exp_idle("R5 rescan winner is source 0");

    // R7 withdraw, R9 idle rise, R10 edge drop keeps request
    do_reset();
    lvl = 16'(1) << 3;
    pend = 16'(1) << 3;
    tick();
    exp_issue("R7 level source issued", 3);
    pend = '0;
    tick();
    exp_idle("R7 level drop withdraws");
    pend = 16'(1) << 4;
    tick();
    exp_issue("R1 request after withdraw", 4);
    pend = '0;
    tick();
    exp_issue("R10 edge source drop holds", 4);
    ack_pulse();
    exp_idle("R5 after edge ack");
    lvl = '0;

    // R8 ack while idle, R9 rise beats older higher source
    do_reset();
    en = ~(16'(1) << 2);
    pend = 16'(1) << 2;
    tick();
    exp_idle("R1 disabled high source waits");
    en = '1;
    ack_pulse();
    exp_idle("R8 ack while idle");
    pend = pend | (16'(1) << 5);
    tick();
    exp_issue("R9 lower rise requested", 5);
    pend = pend | (16'(1) << 7);
    tick();
    exp_issue("R10 rise ignored while busy", 5);
    ack_pulse();
    exp_issue("R5 rescan picks highest", 7);
    ack_pulse();
    exp_issue("R5 rescan next", 2);

    // R5 R6 R10: randomized rescan sweep
    for (int k = 0; k < 60; k++) begin
      int first, e;
      logic [NS-1:0] patt;
      do_reset();
      seed = seed * 32'd1664525 + 32'd1013904223;
      slot_prio = seed[23:8];
      seed = seed * 32'd1664525 + 32'd1013904223;
      en = seed[31:16] | 16'h8421;
      lvl = seed[15:0] & 16'h5A5A;
      seed = seed * 32'd1664525 + 32'd1013904223;
      patt = seed[27:12];
      first = (k % 15) + 1;
      en[first] = 1'b1;
      pend = 16'(1) << first;
      tick();
      exp_issue("R1 sweep first issue", first);
      pend = pend | patt;
      tick();
      exp_issue("R10 sweep hold", first);
      ack_pulse();
      e = scan_expect(pend, lvl[first] ? -1 : first);
      if (e > 0 && en[e]) exp_issue("R5 R6 sweep rescan", e);
      else exp_idle("R5 R6 sweep rescan idle");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule